// File: doc/BRIEF.md
# Temperature Limit Alarm Comparator

This block watches a stream of signed 9-bit temperature samples, each with a resolution of 0.5 °C, and compares every sample against an upper trip limit and a lower release limit. It drives an active-low alarm pin and a status bit, which software can read. It sits behind a temperature converter that presents a sample together with a one-cycle strobe. A small byte-wide write port loads the two limits and a configuration byte. A read strobe stands for a read of the status register.

Two alarm behaviours can be selected. In level mode the alarm follows a trip state with hysteresis. The trip state sets when the temperature goes above the upper limit and clears when it goes below the lower limit. In event mode a single event is raised each time the trip state sets. The event stays latched until software reads it, and no further event can occur until the temperature has gone back below the lower limit. In both modes a fault filter requires a selectable number of consecutive out-of-limit samples before the trip state changes. This keeps isolated bad readings from reaching the alarm.

Top module: `temp_alarm_cmp`

## Requirements
- R1: After reset the alarm pin `alarm_n` is high and `irq_stat` is low. The mode is level mode and the filter depth is 1. The upper limit is 80.0 °C (code 0x0A0) and the lower limit is 75.0 °C (code 0x096).
- R2: A write with `wr_sel`=0 loads bits 8..1 of the upper limit from `wr_data`. `wr_sel`=1 loads bit 0 of the upper limit from `wr_data[7]`. `wr_sel`=2 and `wr_sel`=3 do the same for the lower limit. Writing a limit does not change the alarm state.
- R3: A sample counts as hot when it is strictly greater than the upper limit and as cold when it is strictly less than the lower limit. Both comparisons treat the values as two's-complement; a sample equal to a limit is neither.
- R4: With config bit 0 = 0 (level mode), the alarm is asserted once the trip state sets. It stays asserted for samples inside the band and deasserts once the trip state clears. `irq_stat` equals the alarm level, and `stat_rd` has no effect.
- R5: With config bit 0 = 1 (event mode), the step that sets the trip state raises `irq_stat` and asserts the alarm. Further hot samples raise nothing new. A new event is possible only after the trip state has been cleared by cold samples.
- R6: In event mode a `stat_rd` pulse clears `irq_stat` and releases the alarm. If an event occurs in the same cycle as the read, the event wins and the status stays set.
- R7: Config bits 2..1 select the filter depth: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 6 consecutive hot samples needed to set the trip state. An in-band or cold sample restarts the count. Clock cycles without a sample do not restart it.
- R8: Clearing the trip state needs the same number of consecutive cold samples. An in-band or hot sample restarts that count.
- R9: A write to the configuration byte (`wr_sel`=4) clears the trip state, both filter counts and `irq_stat`.
- R10: The alarm pin and status change on the same clock edge that accepts the qualifying sample. The alarm only ever asserts on an edge that accepts a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_temp | input | 9 | Temperature sample, two's-complement, 0.5 °C per LSB |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0/1 upper limit high/low, 2/3 lower limit high/low, 4 config |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe |
| alarm_n | output | 1 | Alarm pin, active low |
| irq_stat | output | 1 | Alarm status bit |

## Verification
The hardest state to reach is an event that lands in the same cycle as a status read. Getting there takes a full sequence: a trip, a read, a re-arm through cold samples, and then a hot sample issued together with the read strobe. The other hard cases are the filter runs of depth 4 and 6 that are broken by one in-band sample; the stimulus gives one sample too few and then the qualifying one, with idle cycles in between to show that gaps do not reset the count. Limits written through the low-byte path, and negative limits, move the trip points by one LSB and across zero, which tests the signed comparison at its edges.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

    typedef enum logic [2:0] {
        SEL_OVT_HI = 3'd0,
        SEL_OVT_LO = 3'd1,
        SEL_HYS_HI = 3'd2,
        SEL_HYS_LO = 3'd3,
        SEL_CFG    = 3'd4
    } ta_sel_e;

    // filter depth code -> number of consecutive samples
    function automatic int unsigned fault_depth(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/ta_limit_regs.sv
module ta_limit_regs
    import temp_alarm_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter int              TEMP_W  = DATA_W + 1,
    parameter logic [TEMP_W-1:0] DEF_OVT = 9'h0A0,
    parameter logic [TEMP_W-1:0] DEF_HYS = 9'h096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TEMP_W-1:0] ovt_lim,
    output logic [TEMP_W-1:0] hys_lim,
    output logic              evt_mode,
    output logic [1:0]        depth_sel,
    output logic              cfg_wr
);

    typedef struct packed {
        logic [TEMP_W-1:0] ovt;
        logic [TEMP_W-1:0] hys;
        logic              mode;
        logic [1:0]        dsel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        cfg_wr = 1'b0;
        if (wr_en) begin
            case (wr_sel)
                SEL_OVT_HI: r_d.ovt[TEMP_W-1:1] = wr_data;
                SEL_OVT_LO: r_d.ovt[0]          = wr_data[DATA_W-1];
                SEL_HYS_HI: r_d.hys[TEMP_W-1:1] = wr_data;
                SEL_HYS_LO: r_d.hys[0]          = wr_data[DATA_W-1];
                SEL_CFG: begin
                    r_d.mode = wr_data[0];
                    r_d.dsel = wr_data[2:1];
                    cfg_wr   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ovt  <= DEF_OVT;
            r_q.hys  <= DEF_HYS;
            r_q.mode <= 1'b0;
            r_q.dsel <= 2'd0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ovt_lim   = r_q.ovt;
    assign hys_lim   = r_q.hys;
    assign evt_mode  = r_q.mode;
    assign depth_sel = r_q.dsel;

    assert_ovt_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_OVT_HI) |=> (ovt_lim[TEMP_W-1:1] == $past(wr_data)));

    assert_hys_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_HYS_LO) |=> (hys_lim[0] == $past(wr_data[DATA_W-1])));

endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp_valid,
    input  logic             hit,
    input  logic [CNT_W-1:0] need,
    output logic             qual
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_d, run_q;
    logic [CNT_W:0]   run_inc;

    always_comb begin
        run_inc = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};
        run_d   = run_q;
        qual    = 1'b0;
        if (clr) begin
            run_d = '0;
        end else if (smp_valid) begin
            if (hit) begin
                qual  = (run_inc >= {1'b0, need});
                run_d = (run_q == CNT_MAX) ? run_q : run_inc[CNT_W-1:0];
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assert_qual_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (smp_valid && hit && !clr));

    assert_miss_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !hit) |=> (run_q == '0));

endmodule

// File: rtl/ta_alarm_ctrl.sv
module ta_alarm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic evt_mode,
    input  logic q_hot,
    input  logic q_cold,
    input  logic stat_rd,
    output logic stat
);

    typedef struct packed {
        logic tripped;
        logic stat;
    } st_t;

    st_t s_d, s_q;
    logic evt;

    always_comb begin
        s_d = s_q;
        evt = 1'b0;
        if (clr) begin
            s_d = '0;
        end else begin
            if (q_hot)       s_d.tripped = 1'b1;
            else if (q_cold) s_d.tripped = 1'b0;
            evt = s_d.tripped & ~s_q.tripped;
            if (evt_mode) s_d.stat = evt | (s_q.stat & ~stat_rd);
            else          s_d.stat = s_d.tripped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat = s_q.stat;

    assert_event_on_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mode && $rose(s_q.stat)) |-> $rose(s_q.tripped));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mode && stat_rd && s_q.tripped && !clr) |=> !s_q.stat);

    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_mode && q_hot && !clr) |=> s_q.stat);

    assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!s_q.stat && !s_q.tripped));

endmodule

// File: rtl/temp_alarm_cmp.sv
module temp_alarm_cmp
    import temp_alarm_pkg::*;
#(
    parameter int                 DATA_W  = 8,
    parameter int                 CNT_W   = 3,
    parameter logic [DATA_W:0]    DEF_OVT = 9'h0A0,
    parameter logic [DATA_W:0]    DEF_HYS = 9'h096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W:0]   smp_temp,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic              alarm_n,
    output logic              irq_stat
);

    localparam int TEMP_W = DATA_W + 1;
    localparam int N_DIR  = 2;   // 0: hot side, 1: cold side

    logic [TEMP_W-1:0] ovt_lim, hys_lim;
    logic              evt_mode, cfg_wr;
    logic [1:0]        depth_sel;
    logic [CNT_W-1:0]  need;
    logic [N_DIR-1:0]  hit, qual;
    logic              stat;

    ta_limit_regs #(
        .DATA_W (DATA_W),
        .TEMP_W (TEMP_W),
        .DEF_OVT(DEF_OVT),
        .DEF_HYS(DEF_HYS)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ovt_lim  (ovt_lim),
        .hys_lim  (hys_lim),
        .evt_mode (evt_mode),
        .depth_sel(depth_sel),
        .cfg_wr   (cfg_wr)
    );

    always_comb begin
        need   = CNT_W'(fault_depth(depth_sel));
        hit[0] = $signed(smp_temp) > $signed(ovt_lim);
        hit[1] = $signed(smp_temp) < $signed(hys_lim);
    end

    for (genvar g = 0; g < N_DIR; g++) begin : g_fq
        ta_fault_queue #(.CNT_W(CNT_W)) i_fq (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (cfg_wr),
            .smp_valid(smp_valid),
            .hit      (hit[g]),
            .need     (need),
            .qual     (qual[g])
        );
    end

    ta_alarm_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_wr),
        .evt_mode(evt_mode),
        .q_hot   (qual[0]),
        .q_cold  (qual[1]),
        .stat_rd (stat_rd),
        .stat    (stat)
    );

    assign alarm_n  = ~stat;
    assign irq_stat = stat;

    assert_alarm_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_n) |-> $past(smp_valid));

endmodule

// File: tb/test_temp_alarm_cmp.sv
`timescale 1ns/1ps
module test_temp_alarm_cmp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [8:0] smp_temp = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       stat_rd = 1'b0;
    logic       alarm_n, irq_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    temp_alarm_cmp i_temp_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stat_rd(stat_rd),
        .alarm_n(alarm_n), .irq_stat(irq_stat)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_st(input string req, input bit on);
        chk({req, " alarm_n"}, int'(alarm_n), int'(!on));
        chk({req, " irq_stat"}, int'(irq_stat), int'(on));
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_lim(input logic [8:0] ovt, input logic [8:0] hys);
        wr(3'd0, ovt[8:1]); wr(3'd1, {ovt[0], 7'b0});
        wr(3'd2, hys[8:1]); wr(3'd3, {hys[0], 7'b0});
    endtask

    task automatic cfg(input bit mode, input logic [1:0] dsel);
        wr(3'd4, {5'b0, dsel, mode});
    endtask

    task automatic smp(input logic [8:0] t, input bit rd = 1'b0);
        @(negedge clk); smp_valid = 1'b1; smp_temp = t; stat_rd = rd;
        @(negedge clk); smp_valid = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        expect_st("R1 reset", 1'b0);
    endtask

    task automatic t_defaults();
        smp(9'd160); expect_st("R1 default limit 80.0 not hot", 1'b0);
        smp(9'd161); expect_st("R10 trip on accepting edge", 1'b1);
        smp(9'd155); expect_st("R4 held in band", 1'b1);
        rd();        expect_st("R4 read ignored in level mode", 1'b1);
        smp(9'd150); expect_st("R3 equal to lower limit not cold", 1'b1);
        smp(9'd149); expect_st("R4 release below lower limit", 1'b0);
    endtask

    task automatic t_lowbit();
        set_lim(9'd161, 9'd151);
        smp(9'd161); expect_st("R2 upper bit0 loaded", 1'b0);
        smp(9'd162); expect_st("R2 trip above odd limit", 1'b1);
        set_lim(9'd200, 9'd151);
        expect_st("R2 limit write keeps state", 1'b1);
        smp(9'd151); expect_st("R2 lower bit0 loaded", 1'b1);
        smp(9'd150); expect_st("R2 release below odd limit", 1'b0);
    endtask

    task automatic t_signed();
        cfg(1'b0, 2'd0);
        set_lim(9'h1EB, 9'h1E2);          // -10.5 C and -15.0 C
        smp(9'h100); expect_st("R3 most negative not hot", 1'b0);
        smp(9'h1EB); expect_st("R3 equal negative limit", 1'b0);
        smp(9'h1EC); expect_st("R3 above negative limit", 1'b1);
        smp(9'h0C8); expect_st("R3 positive stays hot", 1'b1);
        smp(9'h1E2); expect_st("R3 equal negative lower", 1'b1);
        smp(9'h1E1); expect_st("R3 below negative lower", 1'b0);
    endtask

    task automatic t_fault();
        int depth_tab[4] = '{1, 2, 4, 6};
        set_lim(9'd160, 9'd150);
        for (int i = 0; i < 4; i++) begin
            cfg(1'b0, 2'(i));
            for (int k = 0; k < depth_tab[i] - 1; k++) begin
                smp(9'd170);
                repeat (2) @(negedge clk);
            end
            expect_st("R7 one hot sample short", 1'b0);
            smp(9'd170); expect_st("R7 depth reached", 1'b1);
            for (int k = 0; k < depth_tab[i] - 1; k++) smp(9'd140);
            expect_st("R8 one cold sample short", 1'b1);
            smp(9'd140); expect_st("R8 release depth reached", 1'b0);
        end
        cfg(1'b0, 2'd2);
        for (int k = 0; k < 3; k++) smp(9'd170);
        smp(9'd155);
        for (int k = 0; k < 3; k++) smp(9'd170);
        expect_st("R7 in-band sample restarts run", 1'b0);
        smp(9'd170); expect_st("R7 fresh run of four", 1'b1);
        for (int k = 0; k < 3; k++) smp(9'd140);
        smp(9'd170);
        for (int k = 0; k < 3; k++) smp(9'd140);
        expect_st("R8 hot sample restarts release run", 1'b1);
        smp(9'd140); expect_st("R8 fresh release run", 1'b0);
    endtask

    task automatic t_event();
        cfg(1'b1, 2'd0);
        smp(9'd170); expect_st("R5 event raised", 1'b1);
        smp(9'd170); expect_st("R5 event held", 1'b1);
        rd();        expect_st("R6 read clears", 1'b0);
        smp(9'd170); expect_st("R5 no second event while hot", 1'b0);
        smp(9'd155); expect_st("R5 band no event", 1'b0);
        smp(9'd140); expect_st("R5 re-arm raises nothing", 1'b0);
        smp(9'd170); expect_st("R5 event after re-arm", 1'b1);
        rd();        expect_st("R6 read clears again", 1'b0);
        smp(9'd140); expect_st("R5 re-arm", 1'b0);
        smp(9'd170, 1'b1); expect_st("R6 event wins over read", 1'b1);
        rd();        expect_st("R6 later read clears", 1'b0);
    endtask

    task automatic t_cfgclr();
        cfg(1'b0, 2'd0);
        smp(9'd170); expect_st("R9 level tripped", 1'b1);
        cfg(1'b0, 2'd0); expect_st("R9 config write clears", 1'b0);
        smp(9'd155); expect_st("R9 trip state cleared", 1'b0);
        cfg(1'b1, 2'd0);
        smp(9'd170); rd(); expect_st("R6 cleared before config", 1'b0);
        cfg(1'b1, 2'd0);
        smp(9'd170); expect_st("R9 config write re-arms event", 1'b1);
        cfg(1'b0, 2'd2);
        smp(9'd170); smp(9'd170); smp(9'd170);
        expect_st("R9 counts cleared", 1'b0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_lowbit();
        t_signed();
        t_fault();
        t_event();
        t_cfgclr();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule